// File: doc/BRIEF.md
# Multi-mode 8-bit timer/counter

This block is an 8-bit timer for a microcontroller-style subsystem. A system-level clock-enable tick drives it. A power-of-two prescaler divides that tick into the timer's active ticks. On each active tick the counter steps according to one of four modes:

- **Free-running:** wraps around the full 8-bit range.
- **One-shot down count:** reloads from the period value on start.
- **Modulo:** runs from 0 up to the period value.
- **Up/down:** ramps between 0 and the period value, for centre-aligned PWM.

Two compare channels watch the counter. Each channel drives an output pin that it sets, clears, toggles or leaves alone when the count matches the channel's value.

Software controls the timer through plain control inputs: a run level, a clear strobe, mode and divider selects, the period value, and the per-channel compare values and actions. The counter value is always visible on an output. Overflow and compare events appear as single-cycle flags. Mask bits route the flags onto one interrupt request. Any event also produces a single-cycle trigger pulse for a DMA engine.

Top module: `tmr8_multimode`

## Requirements
- R1: After reset the count is 0x00, both compare pins are 0, and all flags, the interrupt request and the DMA trigger are 0.
- R2: The divider select n (0..7) makes an active tick on every 2^n-th system tick; only cycles with `tick_en_i` high count towards this. The divider restarts whenever the timer is halted or cleared, so the first step after a start comes a full 2^n ticks later.
- R3: Mode 2'b00 (free-running) adds one per active tick and wraps from 0xFF to 0x00. The overflow flag pulses in the cycle the count becomes 0xFF.
- R4: Mode 2'b01 (down) loads the period value when `run_i` rises. It then subtracts one per active tick and pulses the overflow flag when the count becomes 0x00. It then stays at 0x00 until `run_i` rises again.
- R5: Mode 2'b10 (modulo) adds one per active tick. An active tick taken while the count equals the period value returns the count to 0x00 and pulses the overflow flag.
- R6: Mode 2'b11 (up/down) counts up from 0x00 to the period value, then down to 0x00, repeating. The overflow flag pulses when the down ramp reaches 0x00.
- R7: With `run_i` low and no clear, the count holds its value.
- R8: A clear strobe sets the count to 0x00 at the next edge and forces the up/down direction to counting up. The clear takes priority over counting and loading.
- R9: Each channel evaluates its action when an active tick moves the count to the channel's compare value. The pin changes at the same edge as the count. Action code 2'b00 sets the pin, 2'b01 clears it, 2'b10 toggles it, and 2'b11 leaves it unchanged.
- R10: A channel's compare flag pulses for one cycle at each match, whatever its action code. The overflow flag also pulses for one cycle per event.
- R11: The interrupt request is high while the overflow flag is high with `ovf_mask_i` set. It is also high while channel i's flag is high with `cmp_mask_i[i]` set. Otherwise it is low.
- R12: The DMA trigger pulses for one cycle alongside any overflow or compare event, independent of the masks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Clock-enable tick feeding the prescaler |
| run_i | input | 1 | 1 runs the timer, 0 halts it |
| clr_i | input | 1 | Clear strobe |
| mode_i | input | 2 | Counting mode select |
| div_sel_i | input | 3 | Prescaler divide select, divides by 2^n |
| period_i | input | 8 | Period / terminal-count value |
| cmp_val_i | input | 2x8 | Compare value per channel |
| cmp_act_i | input | 2x2 | Compare action code per channel |
| ovf_mask_i | input | 1 | Overflow interrupt mask |
| cmp_mask_i | input | 2 | Compare interrupt mask per channel |
| count_o | output | 8 | Current counter value |
| cmp_out_o | output | 2 | Compare output pin per channel |
| ovf_flag_o | output | 1 | Overflow / terminal-count event pulse |
| cmp_flag_o | output | 2 | Compare event pulse per channel |
| irq_o | output | 1 | Masked interrupt request |
| dma_trig_o | output | 1 | Single-cycle DMA trigger |

## Verification
Some properties are checked on every cycle:
- a halted counter holds its value;
- a clear leaves zero at the next edge;
- free-running mode never steps by more than one, and its overflow flag coincides with 0xFF;
- a running down count never rises;
- a compare pin never changes without its compare flag;
- the DMA trigger never fires without an event flag.

Other behaviours need the bench's directed scenarios:
- the exact counting sequences of each mode;
- where the prescaled steps fall, including the restart after a halt;
- the reload on start;
- the direction reset by a clear during a down ramp;
- the four action codes;
- the effect of the masks on the interrupt.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  typedef enum logic [1:0] {
    M_FREE = 2'b00,
    M_DOWN = 2'b01,
    M_MOD  = 2'b10,
    M_UPDN = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    A_SET  = 2'b00,
    A_CLR  = 2'b01,
    A_TGL  = 2'b10,
    A_HOLD = 2'b11
  } cmp_act_e;

endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale #(
  parameter int SELW = 3
) (
  input  logic            clk_i,
  input  logic            rst_n,
  input  logic            tick_en_i,
  input  logic            run_i,
  input  logic            clr_i,
  input  logic [SELW-1:0] div_sel_i,
  output logic            act_o
);
  localparam int PCW = (1 << SELW) - 1;

  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic [PCW-1:0] pmask;
  logic           pcnt_en;

  // all-ones low n bits mark the last tick of a divided period
  assign pmask = (PCW'(1) << div_sel_i) - PCW'(1);
  assign act_o = tick_en_i & run_i & ~clr_i & ((pcnt_q & pmask) == pmask);

  always_comb begin
    pcnt_en = 1'b0;
    pcnt_d  = pcnt_q;
    if (clr_i || !run_i) begin
      pcnt_en = 1'b1;
      pcnt_d  = '0;
    end else if (tick_en_i) begin
      pcnt_en = 1'b1;
      pcnt_d  = pcnt_q + PCW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_en) pcnt_q <= pcnt_d;
  end

endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
  import tmr8_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_n,
  input  logic          act_i,
  input  logic          start_i,
  input  logic          clr_i,
  input  cnt_mode_e     mode_i,
  input  logic [CW-1:0] period_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o,
  output logic          ovf_now_o,
  output logic          ovf_flag_o
);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] ZERO = '0;
  localparam logic [CW-1:0] TOP  = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          up_q, up_d;
  logic          ovf_q, ovf_d;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    ovf_d = 1'b0;
    if (clr_i) begin
      cnt_d = ZERO;
      up_d  = 1'b1;
    end else if (start_i && mode_i == M_DOWN) begin
      cnt_d = period_i;
    end else if (act_i) begin
      case (mode_i)
        M_FREE: begin
          cnt_d = cnt_q + ONE;
          ovf_d = (cnt_q == TOP - ONE);
        end
        M_DOWN: begin
          if (cnt_q != ZERO) begin
            cnt_d = cnt_q - ONE;
            ovf_d = (cnt_q == ONE);
          end
        end
        M_MOD: begin
          if (cnt_q == period_i) begin
            cnt_d = ZERO;
            ovf_d = 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        M_UPDN: begin
          if (up_q && cnt_q < period_i) begin
            cnt_d = cnt_q + ONE;
            up_d  = ((cnt_q + ONE) != period_i);
          end else begin
            // falling ramp, or period lowered below the count
            if (cnt_q != ZERO) cnt_d = cnt_q - ONE;
            up_d  = (cnt_q <= ONE);
            ovf_d = (cnt_q == ONE);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign cnt_nxt_o  = cnt_d;
  assign ovf_now_o  = ovf_d;
  assign ovf_flag_o = ovf_q;

endmodule

// File: rtl/tmr8_cmp_ch.sv
module tmr8_cmp_ch
  import tmr8_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_n,
  input  logic          act_i,
  input  logic [CW-1:0] cnt_nxt_i,
  input  logic [CW-1:0] cmp_val_i,
  input  cmp_act_e      action_i,
  output logic          hit_now_o,
  output logic          hit_o,
  output logic          pin_o
);
  logic pin_q, pin_d;
  logic hit_q;

  assign hit_now_o = act_i & (cnt_nxt_i == cmp_val_i);

  always_comb begin
    pin_d = pin_q;
    if (hit_now_o) begin
      case (action_i)
        A_SET:  pin_d = 1'b1;
        A_CLR:  pin_d = 1'b0;
        A_TGL:  pin_d = ~pin_q;
        A_HOLD: pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      pin_q <= pin_d;
      hit_q <= hit_now_o;
    end
  end

  assign pin_o = pin_q;
  assign hit_o = hit_q;

endmodule

// File: rtl/tmr8_evt.sv
module tmr8_evt #(
  parameter int NCH = 2
) (
  input  logic           clk_i,
  input  logic           rst_n,
  input  logic           ovf_now_i,
  input  logic [NCH-1:0] hit_now_i,
  input  logic           ovf_flag_i,
  input  logic [NCH-1:0] cmp_flag_i,
  input  logic           ovf_mask_i,
  input  logic [NCH-1:0] cmp_mask_i,
  output logic           irq_o,
  output logic           dma_o
);
  logic dma_q, dma_d;

  assign dma_d = ovf_now_i | (|hit_now_i);
  assign irq_o = (ovf_flag_i & ovf_mask_i) | (|(cmp_flag_i & cmp_mask_i));

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) dma_q <= 1'b0;
    else        dma_q <= dma_d;
  end

  assign dma_o = dma_q;

endmodule

// File: rtl/tmr8_multimode.sv
module tmr8_multimode
  import tmr8_pkg::*;
#(
  parameter int CW   = 8,
  parameter int SELW = 3,
  parameter int NCH  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_n_i,
  input  logic                     tick_en_i,
  input  logic                     run_i,
  input  logic                     clr_i,
  input  logic [1:0]               mode_i,
  input  logic [SELW-1:0]          div_sel_i,
  input  logic [CW-1:0]            period_i,
  input  logic [NCH-1:0][CW-1:0]   cmp_val_i,
  input  logic [NCH-1:0][1:0]      cmp_act_i,
  input  logic                     ovf_mask_i,
  input  logic [NCH-1:0]           cmp_mask_i,
  output logic [CW-1:0]            count_o,
  output logic [NCH-1:0]           cmp_out_o,
  output logic                     ovf_flag_o,
  output logic [NCH-1:0]           cmp_flag_o,
  output logic                     irq_o,
  output logic                     dma_trig_o
);
  logic [1:0]     rsync_q;
  logic           rst_n;
  logic           run_q;
  logic           start;
  logic           act;
  logic [CW-1:0]  cnt_nxt;
  logic           ovf_now;
  logic [NCH-1:0] hit_now;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rsync_q <= 2'b00;
    else          rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_i;
  end
  assign start = run_i & ~run_q;

  tmr8_prescale #(.SELW(SELW)) u_pre (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .tick_en_i (tick_en_i),
    .run_i     (run_i),
    .clr_i     (clr_i),
    .div_sel_i (div_sel_i),
    .act_o     (act)
  );

  tmr8_core #(.CW(CW)) u_core (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .act_i      (act),
    .start_i    (start),
    .clr_i      (clr_i),
    .mode_i     (cnt_mode_e'(mode_i)),
    .period_i   (period_i),
    .cnt_o      (count_o),
    .cnt_nxt_o  (cnt_nxt),
    .ovf_now_o  (ovf_now),
    .ovf_flag_o (ovf_flag_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr8_cmp_ch #(.CW(CW)) u_ch (
      .clk_i     (clk_i),
      .rst_n     (rst_n),
      .act_i     (act),
      .cnt_nxt_i (cnt_nxt),
      .cmp_val_i (cmp_val_i[g]),
      .action_i  (cmp_act_e'(cmp_act_i[g])),
      .hit_now_o (hit_now[g]),
      .hit_o     (cmp_flag_o[g]),
      .pin_o     (cmp_out_o[g])
    );
  end

  tmr8_evt #(.NCH(NCH)) u_evt (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .ovf_now_i  (ovf_now),
    .hit_now_i  (hit_now),
    .ovf_flag_i (ovf_flag_o),
    .cmp_flag_i (cmp_flag_o),
    .ovf_mask_i (ovf_mask_i),
    .cmp_mask_i (cmp_mask_i),
    .irq_o      (irq_o),
    .dma_o      (dma_trig_o)
  );

endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk #(
  parameter int CW  = 8,
  parameter int NCH = 2
) (
  input logic           clk_i,
  input logic           rst_n,
  input logic           run_i,
  input logic           clr_i,
  input logic [1:0]     mode_i,
  input logic [CW-1:0]  count_o,
  input logic [NCH-1:0] cmp_out_o,
  input logic           ovf_flag_o,
  input logic [NCH-1:0] cmp_flag_o,
  input logic           dma_trig_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic run_d;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) run_d <= 1'b0;
    else        run_d <= run_i;
  end

  p_hold_count_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!run_i && !clr_i) |=> $stable(count_o));

  p_clear_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    clr_i |=> (count_o == '0));

  p_free_step_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run_i && !clr_i && mode_i == 2'b00) |=>
      (count_o == $past(count_o) || count_o == $past(count_o) + ONE));

  p_free_ovf_top_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run_i && !clr_i && mode_i == 2'b00) |=> (ovf_flag_o |-> count_o == '1));

  p_down_no_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run_i && run_d && !clr_i && mode_i == 2'b01) |=> (count_o <= $past(count_o)));

  for (genvar g = 0; g < NCH; g++) begin : g_pin
    p_pin_needs_hit_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
      (cmp_out_o[g] != $past(cmp_out_o[g])) |-> cmp_flag_o[g]);
  end

  p_dma_needs_event_r12: assert property (@(posedge clk_i) disable iff (!rst_n)
    dma_trig_o |-> (ovf_flag_o || (|cmp_flag_o)));

endmodule

bind tmr8_multimode tmr8_chk #(.CW(CW), .NCH(NCH)) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n),
  .run_i      (run_i),
  .clr_i      (clr_i),
  .mode_i     (mode_i),
  .count_o    (count_o),
  .cmp_out_o  (cmp_out_o),
  .ovf_flag_o (ovf_flag_o),
  .cmp_flag_o (cmp_flag_o),
  .dma_trig_o (dma_trig_o)
);

// File: tb/test_tmr8_multimode.sv
module test_tmr8_multimode;
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            tick_en, run, clr, ovf_mask;
  logic [1:0]      mode;
  logic [2:0]      div_sel;
  logic [7:0]      period;
  logic [1:0][7:0] cmp_val;
  logic [1:0][1:0] cmp_act;
  logic [1:0]      cmp_mask;
  logic [7:0]      count;
  logic [1:0]      cmp_out, cmp_flag;
  logic            ovf_flag, irq, dma;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr8_multimode i_tmr8_multimode (
    .clk_i(clk), .rst_n_i(rst_n), .tick_en_i(tick_en), .run_i(run), .clr_i(clr),
    .mode_i(mode), .div_sel_i(div_sel), .period_i(period), .cmp_val_i(cmp_val),
    .cmp_act_i(cmp_act), .ovf_mask_i(ovf_mask), .cmp_mask_i(cmp_mask),
    .count_o(count), .cmp_out_o(cmp_out), .ovf_flag_o(ovf_flag),
    .cmp_flag_o(cmp_flag), .irq_o(irq), .dma_trig_o(dma)
  );

  typedef enum {K_CNT, K_OVF, K_CF0, K_CF1, K_OUT0, K_OUT1, K_IRQ, K_DMA} kind_e;
  typedef struct {
    int    at;
    kind_e k;
    int    val;
    string req;
  } exp_t;

  exp_t sbq[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int actual(kind_e k);
    case (k)
      K_CNT:   return int'(count);
      K_OVF:   return int'(ovf_flag);
      K_CF0:   return int'(cmp_flag[0]);
      K_CF1:   return int'(cmp_flag[1]);
      K_OUT0:  return int'(cmp_out[0]);
      K_OUT1:  return int'(cmp_out[1]);
      K_IRQ:   return int'(irq);
      K_DMA:   return int'(dma);
      default: return -1;
    endcase
  endfunction

  // driver side: queue an expectation d edges ahead
  task automatic expect_at(int d, kind_e k, int v, string r);
    exp_t e;
    e.at = cyc + d; e.k = k; e.val = v; e.req = r;
    sbq.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor side: pop and compare items due this cycle
  always @(posedge clk) begin
    #2;
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      exp_t e;
      int   a;
      e = sbq.pop_front();
      n_chk++;
      if (e.at < cyc) begin
        n_fail++;
        $display("FAIL %s %s missed at cycle %0d actual %0d expected %0d",
                 e.req, e.k.name(), e.at, -1, e.val);
      end else begin
        a = actual(e.k);
        if (a != e.val) begin
          n_fail++;
          $display("FAIL %s %s cycle %0d actual %0d expected %0d",
                   e.req, e.k.name(), cyc, a, e.val);
        end
      end
    end
  end

  task automatic clear_pulse();
    clr = 1'b1; tick(1); clr = 1'b0; tick(1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b1; run = 1'b0; clr = 1'b0; mode = 2'b00;
    div_sel = 3'd0; period = 8'd0; cmp_val[0] = 8'h10; cmp_val[1] = 8'h20;
    cmp_act[0] = 2'b11; cmp_act[1] = 2'b11; ovf_mask = 1'b1; cmp_mask = 2'b00;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    expect_at(1, K_CNT, 0, "R1"); expect_at(1, K_OUT0, 0, "R1");
    expect_at(1, K_OUT1, 0, "R1"); expect_at(1, K_OVF, 0, "R1");
    expect_at(1, K_CF0, 0, "R1"); expect_at(1, K_CF1, 0, "R1");
    expect_at(1, K_IRQ, 0, "R1"); expect_at(1, K_DMA, 0, "R1");
    tick(2);

    // R3 free-running wrap, overflow at 0xFF, R11/R12 on overflow
    for (int d = 1; d <= 258; d++) begin
      expect_at(d, K_CNT, d % 256, "R3");
      expect_at(d, K_OVF, (d == 255) ? 1 : 0, "R3");
      if (d == 255) begin
        expect_at(d, K_IRQ, 1, "R11");
        expect_at(d, K_DMA, 1, "R12");
      end
      if (d == 256) begin
        expect_at(d, K_IRQ, 0, "R10");
        expect_at(d, K_DMA, 0, "R12");
      end
    end
    run = 1'b1;
    tick(258);

    // R7 halt holds the count
    run = 1'b0;
    for (int d = 1; d <= 5; d++) expect_at(d, K_CNT, 2, "R7");
    tick(5);
    // R8 clear while halted
    expect_at(1, K_CNT, 0, "R8");
    clear_pulse();

    // R2 divide by 4
    div_sel = 3'd2;
    expect_at(3, K_CNT, 0, "R2"); expect_at(4, K_CNT, 1, "R2");
    expect_at(7, K_CNT, 1, "R2"); expect_at(8, K_CNT, 2, "R2");
    run = 1'b1;
    tick(10);
    run = 1'b0;
    tick(1);
    // R2 divider restarts after halt
    expect_at(3, K_CNT, 2, "R2"); expect_at(4, K_CNT, 3, "R2");
    run = 1'b1;
    tick(4);
    // R2 only enabled ticks count
    div_sel = 3'd0;
    tick_en = 1'b0;
    for (int d = 1; d <= 3; d++) expect_at(d, K_CNT, 3, "R2");
    tick(3);
    tick_en = 1'b1;
    expect_at(1, K_CNT, 4, "R2");
    tick(1);
    // R2 divide by 128
    run = 1'b0;
    clear_pulse();
    div_sel = 3'd7;
    expect_at(127, K_CNT, 0, "R2"); expect_at(128, K_CNT, 1, "R2");
    run = 1'b1;
    tick(128);
    run = 1'b0;
    div_sel = 3'd0;
    clear_pulse();

    // R4 down mode
    mode = 2'b01; period = 8'd5;
    expect_at(1, K_CNT, 5, "R4");
    for (int d = 2; d <= 9; d++) begin
      expect_at(d, K_CNT, (d <= 6) ? 6 - d : 0, "R4");
      expect_at(d, K_OVF, (d == 6) ? 1 : 0, "R4");
    end
    run = 1'b1;
    tick(9);
    run = 1'b0;
    tick(1);
    expect_at(1, K_CNT, 5, "R4");
    run = 1'b1;
    tick(1);
    run = 1'b0;
    clear_pulse();

    // R5 modulo mode
    mode = 2'b10; period = 8'd3;
    for (int d = 1; d <= 8; d++) begin
      expect_at(d, K_CNT, d % 4, "R5");
      expect_at(d, K_OVF, (d % 4 == 0) ? 1 : 0, "R5");
    end
    run = 1'b1;
    tick(8);
    run = 1'b0;
    clear_pulse();

    // R6 up/down mode
    mode = 2'b11; period = 8'd3;
    begin
      int seq [10] = '{1, 2, 3, 2, 1, 0, 1, 2, 3, 2};
      for (int d = 1; d <= 10; d++) begin
        expect_at(d, K_CNT, seq[d-1], "R6");
        expect_at(d, K_OVF, (d == 6) ? 1 : 0, "R6");
      end
    end
    run = 1'b1;
    tick(10);
    // R8 clear on the down ramp: next step counts up
    expect_at(1, K_CNT, 0, "R8"); expect_at(2, K_CNT, 1, "R8");
    clr = 1'b1; tick(1); clr = 1'b0; tick(1);
    run = 1'b0;
    clear_pulse();

    // R9/R10/R11/R12 compare channels in modulo 8
    mode = 2'b10; period = 8'd7; ovf_mask = 1'b0; cmp_mask = 2'b10;
    cmp_val[0] = 8'd4; cmp_act[0] = 2'b00;
    cmp_val[1] = 8'd6; cmp_act[1] = 2'b10;
    expect_at(3, K_OUT0, 0, "R9"); expect_at(3, K_CF0, 0, "R10");
    expect_at(4, K_OUT0, 1, "R9"); expect_at(4, K_CF0, 1, "R10");
    expect_at(4, K_IRQ, 0, "R11"); expect_at(4, K_DMA, 1, "R12");
    expect_at(5, K_CF0, 0, "R10"); expect_at(5, K_OUT0, 1, "R9");
    expect_at(6, K_OUT1, 1, "R9"); expect_at(6, K_CF1, 1, "R10");
    expect_at(6, K_IRQ, 1, "R11"); expect_at(6, K_DMA, 1, "R12");
    expect_at(7, K_CF1, 0, "R10"); expect_at(7, K_IRQ, 0, "R11");
    expect_at(7, K_DMA, 0, "R12");
    expect_at(8, K_OVF, 1, "R5"); expect_at(8, K_IRQ, 0, "R11");
    expect_at(8, K_DMA, 1, "R12");
    run = 1'b1;
    tick(10);
    cmp_act[0] = 2'b01;
    expect_at(2, K_OUT0, 0, "R9"); expect_at(2, K_CF0, 1, "R10");
    expect_at(4, K_OUT1, 0, "R9"); expect_at(4, K_CF1, 1, "R10");
    tick(5);
    cmp_act[0] = 2'b11;
    expect_at(5, K_OUT0, 0, "R9"); expect_at(5, K_CF0, 1, "R10");
    expect_at(7, K_OUT1, 1, "R9");
    tick(8);
    run = 1'b0;
    tick(3);

    if (sbq.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard leftover actual %0d expected %0d", sbq.size(), 0);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule